// File: doc/BRIEF.md
# Modular Exponentiation Bus Front End

This block sits between a plain 32-bit chip-select/write-enable bus and a modular exponentiation engine. One address bit splits the bus space in two. One half holds a few control and status registers. The other half holds eight operand banks of 32-bit words, and the block stores those banks itself. Software loads the modulus, the message and the exponent one word at a time, least significant word at index 0. It launches a precomputation or an exponentiation by making a CONTROL bit rise, then polls STATUS and reads the result words back.

The arithmetic core is out of scope. A behavioural stand-in runs in its place. It walks one word per clock over the operand length set by the modulus bit count, fills the precomputed banks or the result bank with simple word-wise functions, and then raises ready or valid. Every bus access takes one cycle and cannot be stalled, so there is no back-pressure at the edge: a read returns its data in the same cycle and a write commits at the clock edge that samples it.

Top module: `mexp_bus_front`

## Requirements
- R1: The address is OP_AW+4 bits wide. When the top bit is 1, bits [OP_AW+2:OP_AW] pick a bank and bits [OP_AW-1:0] pick a word in it. When the top bit is 0, the low OP_AW+3 bits are a register offset.
- R2: A read (chip select high, write enable low) returns its data combinationally in the same cycle. rdata is zero when no read is in progress.
- R3: CONTROL at offset 0x08 stores bit 0 (init) and bit 1 (next) and reads them back. A 0-to-1 change of a stored bit gives one single-cycle start pulse. Writing the same value again gives no pulse.
- R4: MODE at offset 0x10 and MODULUS_BITS at offset 0x11 are 32-bit registers that can be written and read back.
- R5: STATUS at offset 0x09 reads ready in bit 0 and valid in bit 1. Writes to it have no effect.
- R6: The operation length n is ceil(MODULUS_BITS/32). It is replaced by 2**OP_AW when it is 0 or larger than that. After the write edge that raises init, ready rises at the (n+1)-th clock edge.
- R7: An init pulse clears both ready and valid at the next edge. A next pulse clears valid only, and ready keeps its value.
- R8: After init, for i < n, bank 4 word i = modulus word i + 1 (mod 2**32) and bank 6 word i = bitwise NOT of modulus word i, where the modulus is bank 0.
- R9: After next, for i < n, bank 3 word i = message word i XOR exponent word i XOR MODE, where the message is bank 1 and the exponent is bank 2. Valid rises at the (n+1)-th edge after the write edge and stays set until the next command.
- R10: Banks 0, 1, 2, 5 and 7 accept bus writes and read them back. Bus writes to banks 3, 4 and 6 have no effect.
- R11: Reads of any register offset other than 0x08, 0x09, 0x10 and 0x11 return zero.
- R12: If one write raises init and next together, only init runs. Valid stays clear and ready rises as in R6.
- R13: An active-low asynchronous reset clears CONTROL, MODE, MODULUS_BITS, ready and valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select; one access per cycle while high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OP_AW+4 | Space bit, then bank/word or register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
Register and bank reads are due in the same cycle as the access. The bench drives each access at a falling edge and compares the result shortly after, before the next rising edge. Ready and valid are due n+1 rising edges after the edge that samples the CONTROL write. The bench reads STATUS once in the cycle just before that edge, expecting the flag low, and once just after it, expecting the flag high. Clearing by a new command shows one edge after the write edge, so the bench waits one extra cycle before its read. This placement also catches a flag that changes too early or too late by a single cycle.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam int DATA_W   = 32;
  localparam int BANK_W   = 3;
  localparam int OFF_CTRL = 8;
  localparam int OFF_STAT = 9;
  localparam int OFF_MODE = 16;
  localparam int OFF_NBIT = 17;

  // bank codes: operands, result, core-filled, bus copies
  localparam logic [BANK_W-1:0] BK_MOD  = 3'd0;
  localparam logic [BANK_W-1:0] BK_MSG  = 3'd1;
  localparam logic [BANK_W-1:0] BK_EXP  = 3'd2;
  localparam logic [BANK_W-1:0] BK_RES  = 3'd3;
  localparam logic [BANK_W-1:0] BK_PREA = 3'd4;
  localparam logic [BANK_W-1:0] BK_PREB = 3'd6;
endpackage

// File: rtl/mexp_regs.sv
module mexp_regs
  import mexp_pkg::*;
#(
  parameter int OFF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic              valid,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] nbits,
  output logic              init_pulse,
  output logic              next_pulse
);
  logic [1:0] ctrl, ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ctrl_q <= '0;
      mode   <= '0;
      nbits  <= '0;
    end else begin
      ctrl_q <= ctrl;
      if (sel && we) begin
        if (off == OFF_W'(OFF_CTRL)) ctrl  <= wdata[1:0];
        if (off == OFF_W'(OFF_MODE)) mode  <= wdata;
        if (off == OFF_W'(OFF_NBIT)) nbits <= wdata;
      end
    end
  end

  assign init_pulse = ctrl[0] & ~ctrl_q[0];
  assign next_pulse = ctrl[1] & ~ctrl_q[1];

  always_comb begin
    rdata = '0;
    if (sel && !we) begin
      if (off == OFF_W'(OFF_CTRL)) rdata = {{(DATA_W-2){1'b0}}, ctrl};
      if (off == OFF_W'(OFF_STAT)) rdata = {{(DATA_W-2){1'b0}}, valid, ready};
      if (off == OFF_W'(OFF_MODE)) rdata = mode;
      if (off == OFF_W'(OFF_NBIT)) rdata = nbits;
    end
  end

  // R3
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);
  // R3
  next_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_pulse |=> !next_pulse);
endmodule

// File: rtl/mexp_store.sv
module mexp_store
  import mexp_pkg::*;
#(
  parameter int OP_AW = 4
) (
  input  logic              clk,
  input  logic              bus_wr,
  input  logic [BANK_W-1:0] bus_bank,
  input  logic [OP_AW-1:0]  bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [OP_AW-1:0]  core_idx,
  input  logic              pre_we,
  input  logic [DATA_W-1:0] pre_a,
  input  logic [DATA_W-1:0] pre_b,
  input  logic              res_we,
  input  logic [DATA_W-1:0] res_d,
  output logic [DATA_W-1:0] mod_w,
  output logic [DATA_W-1:0] msg_w,
  output logic [DATA_W-1:0] exp_w
);
  localparam int WORDS = 2 ** OP_AW;
  localparam int NBANK = 2 ** BANK_W;

  logic [NBANK-1:0][DATA_W-1:0] bank_rd;
  logic [2:0][DATA_W-1:0]       src_rd;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] words [WORDS];
    if (b == int'(BK_PREA)) begin : g_pa
      always_ff @(posedge clk) if (pre_we) words[core_idx] <= pre_a;
    end else if (b == int'(BK_PREB)) begin : g_pb
      always_ff @(posedge clk) if (pre_we) words[core_idx] <= pre_b;
    end else if (b == int'(BK_RES)) begin : g_rs
      always_ff @(posedge clk) if (res_we) words[core_idx] <= res_d;
    end else begin : g_bw
      always_ff @(posedge clk)
        if (bus_wr && bus_bank == BANK_W'(b)) words[bus_word] <= bus_wdata;
    end
    assign bank_rd[b] = words[bus_word];
    if (b < 3) begin : g_src
      assign src_rd[b] = words[core_idx];
    end
  end

  assign bus_rdata = bank_rd[bus_bank];
  assign mod_w = src_rd[BK_MOD];
  assign msg_w = src_rd[BK_MSG];
  assign exp_w = src_rd[BK_EXP];
endmodule

// File: rtl/mexp_core_stub.sv
module mexp_core_stub
  import mexp_pkg::*;
#(
  parameter int OP_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_pulse,
  input  logic              next_pulse,
  input  logic [DATA_W-1:0] mode,
  input  logic [DATA_W-1:0] nbits,
  input  logic [DATA_W-1:0] mod_w,
  input  logic [DATA_W-1:0] msg_w,
  input  logic [DATA_W-1:0] exp_w,
  output logic [OP_AW-1:0]  core_idx,
  output logic              pre_we,
  output logic [DATA_W-1:0] pre_a,
  output logic [DATA_W-1:0] pre_b,
  output logic              res_we,
  output logic [DATA_W-1:0] res_d,
  output logic              ready_o,
  output logic              valid_o
);
  localparam int WORDS = 2 ** OP_AW;
  localparam int WSH   = $clog2(DATA_W);
  localparam int NW_W  = DATA_W + 1 - WSH;

  logic              busy, op_init;
  logic [OP_AW-1:0]  idx, last;
  logic [DATA_W:0]   rounded;
  logic [NW_W-1:0]   nw;
  logic [OP_AW-1:0]  last_calc;

  assign rounded = {1'b0, nbits} + (DATA_W+1)'(DATA_W - 1);
  assign nw      = rounded[DATA_W:WSH];
  assign last_calc = (nw == '0 || nw > NW_W'(WORDS)) ? OP_AW'(WORDS - 1)
                                                      : OP_AW'(nw - NW_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_init <= 1'b0; idx <= '0; last <= '0;
      ready_o <= 1'b0; valid_o <= 1'b0;
    end else if (init_pulse) begin
      busy <= 1'b1; op_init <= 1'b1; idx <= '0; last <= last_calc;
      ready_o <= 1'b0; valid_o <= 1'b0;
    end else if (next_pulse) begin
      busy <= 1'b1; op_init <= 1'b0; idx <= '0; last <= last_calc;
      valid_o <= 1'b0;
    end else if (busy) begin
      idx <= idx + OP_AW'(1);
      if (idx == last) begin
        busy <= 1'b0;
        if (op_init) ready_o <= 1'b1;
        else         valid_o <= 1'b1;
      end
    end
  end

  assign core_idx = idx;
  assign pre_we   = busy & op_init;
  assign res_we   = busy & ~op_init;
  assign pre_a    = mod_w + DATA_W'(1);
  assign pre_b    = ~mod_w;
  assign res_d    = msg_w ^ exp_w ^ mode;

  // R7
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (!ready_o && !valid_o));
  // R7
  next_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_pulse && !init_pulse) |=> !valid_o);
  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(busy && op_init));
  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(busy && !op_init));
endmodule

// File: rtl/mexp_bus_front.sv
module mexp_bus_front
  import mexp_pkg::*;
#(
  parameter int OP_AW = 4,
  localparam int AW   = OP_AW + 4,
  localparam int OFF_W = OP_AW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              bank_sp, reg_sel;
  logic [BANK_W-1:0] bank;
  logic [OP_AW-1:0]  word;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] reg_rd, bank_rd, mode, nbits;
  logic [DATA_W-1:0] mod_w, msg_w, exp_w, pre_a, pre_b, res_d;
  logic [OP_AW-1:0]  core_idx;
  logic              init_pulse, next_pulse, ready, valid, pre_we, res_we;

  assign bank_sp = bus_addr[AW-1];
  assign bank    = bus_addr[OP_AW+2:OP_AW];
  assign word    = bus_addr[OP_AW-1:0];
  assign off     = bus_addr[OFF_W-1:0];
  assign reg_sel = bus_cs & ~bank_sp;

  mexp_regs #(.OFF_W(OFF_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(bus_we), .off(off),
    .wdata(bus_wdata), .ready(ready), .valid(valid), .rdata(reg_rd),
    .mode(mode), .nbits(nbits), .init_pulse(init_pulse), .next_pulse(next_pulse)
  );

  mexp_store #(.OP_AW(OP_AW)) i_store (
    .clk(clk), .bus_wr(bus_cs & bus_we & bank_sp), .bus_bank(bank),
    .bus_word(word), .bus_wdata(bus_wdata), .bus_rdata(bank_rd),
    .core_idx(core_idx), .pre_we(pre_we), .pre_a(pre_a), .pre_b(pre_b),
    .res_we(res_we), .res_d(res_d), .mod_w(mod_w), .msg_w(msg_w), .exp_w(exp_w)
  );

  mexp_core_stub #(.OP_AW(OP_AW)) i_core (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .next_pulse(next_pulse),
    .mode(mode), .nbits(nbits), .mod_w(mod_w), .msg_w(msg_w), .exp_w(exp_w),
    .core_idx(core_idx), .pre_we(pre_we), .pre_a(pre_a), .pre_b(pre_b),
    .res_we(res_we), .res_d(res_d), .ready_o(ready), .valid_o(valid)
  );

  assign bus_rdata = (bus_cs && !bus_we) ? (bank_sp ? bank_rd : reg_rd) : '0;

  logic known_off;
  assign known_off = (off == OFF_W'(OFF_CTRL)) || (off == OFF_W'(OFF_STAT)) ||
                     (off == OFF_W'(OFF_MODE)) || (off == OFF_W'(OFF_NBIT));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && !bank_sp && !known_off) |-> (bus_rdata == '0));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (bus_rdata == '0));
endmodule

// File: tb/test_mexp_bus_front.sv
`timescale 1ns/1ps
module test_mexp_bus_front;
  localparam int OP_AW = 4;
  localparam int AW    = OP_AW + 4;
  localparam int WORDS = 2 ** OP_AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cs = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mexp_bus_front #(.OP_AW(OP_AW)) i_mexp_bus_front (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [AW-1:0] ra(int o);
    return {1'b0, (AW-1)'(o)};
  endfunction
  function automatic logic [AW-1:0] ba(int b, int w);
    return {1'b1, 3'(b), OP_AW'(w)};
  endfunction
  function automatic logic [31:0] modw(int i);
    return (i == 0) ? 32'hFFFF_FFFF : (32'h1357_0000 ^ (32'(i) * 32'h0101_0301));
  endfunction
  function automatic logic [31:0] msgw(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'd7;
  endfunction
  function automatic logic [31:0] expw(int i);
    return {16'(i), 16'hBEEF};
  endfunction

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask
  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0;
  endtask
  task automatic cmd(logic [31:0] v);
    wr(ra(8), 32'd0);
    wr(ra(8), v);
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each read with the front of the queue
  always @(negedge clk) begin
    #2;
    if (bus_cs && !bus_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    rd(ra(8), 0, "R13 ctrl");  rd(ra(9), 0, "R13 status");
    rd(ra(16), 0, "R13 mode"); rd(ra(17), 0, "R13 nbits");
    // R11 unmapped offsets
    rd(ra(0), 0, "R11 off0"); rd(ra(10), 0, "R11 off10");
    rd(ra(18), 0, "R11 off18"); rd(ra(127), 0, "R11 off127");
    // R5 status write ignored
    wr(ra(9), 32'h3); rd(ra(9), 0, "R5 status write");
    // R4 register readback
    wr(ra(16), 32'h5A5A_0F0F); wr(ra(17), 32'd384);
    rd(ra(16), 32'h5A5A_0F0F, "R4 mode"); rd(ra(17), 32'd384, "R4 nbits");
    // R1 R10 operand loads
    for (int i = 0; i < WORDS; i++) begin
      wr(ba(0, i), modw(i)); wr(ba(1, i), msgw(i)); wr(ba(2, i), expw(i));
    end
    rd(ba(0, 0), modw(0), "R1 mod w0"); rd(ba(0, 11), modw(11), "R1 mod w11");
    rd(ba(2, 5), expw(5), "R10 exp w5");
    // R6 init timing, n = 12
    cmd(32'd1);
    idle(12);
    rd(ra(9), 0, "R6 ready before");
    rd(ra(9), 1, "R6 ready due");
    rd(ra(8), 1, "R3 ctrl readback");
    // R8 precomputed banks
    for (int i = 0; i < 12; i++) begin
      rd(ba(4, i), modw(i) + 32'd1, "R8 bank4");
      rd(ba(6, i), ~modw(i), "R8 bank6");
    end
    // R10 read-only bank and copy banks
    wr(ba(4, 0), 32'hDEAD_BEEF); rd(ba(4, 0), 32'h0, "R10 bank4 ro");
    for (int i = 0; i < 12; i++) begin
      wr(ba(5, i), modw(i) + 32'd1); wr(ba(7, i), ~modw(i));
    end
    rd(ba(5, 3), modw(3) + 32'd1, "R10 bank5"); rd(ba(7, 11), ~modw(11), "R10 bank7");
    // R3 same value again: no pulse, ready stays
    wr(ra(8), 32'd1); idle(1);
    rd(ra(9), 1, "R3 no repulse");
    // R9 next operation
    cmd(32'd2);
    idle(12);
    rd(ra(9), 1, "R9 valid before");
    rd(ra(9), 3, "R9 valid due");
    for (int i = 0; i < 12; i++)
      rd(ba(3, i), msgw(i) ^ expw(i) ^ 32'h5A5A_0F0F, "R9 result");
    wr(ba(3, 0), 32'h0); rd(ba(3, 0), msgw(0) ^ expw(0) ^ 32'h5A5A_0F0F, "R10 bank3 ro");
    rd(ra(9), 3, "R9 valid held");
    // R7 init clears both flags
    cmd(32'd1); idle(1);
    rd(ra(9), 0, "R7 init clears");
    idle(12);
    rd(ra(9), 1, "R7 ready back");
    // R7 next clears valid only
    cmd(32'd2); idle(1);
    rd(ra(9), 1, "R7 next keeps ready");
    idle(12);
    rd(ra(9), 3, "R7 valid back");
    // R12 both bits together, n = 2
    wr(ra(17), 32'd64);
    cmd(32'd3);
    idle(2);
    rd(ra(9), 0, "R12 before");
    rd(ra(9), 1, "R12 init only");
    idle(4);
    rd(ra(9), 1, "R12 valid stays clear");
    // R6 zero length -> full WORDS
    wr(ra(17), 32'd0);
    cmd(32'd1);
    idle(WORDS);
    rd(ra(9), 0, "R6 full before");
    rd(ra(9), 1, "R6 full due");
    rd(ba(4, WORDS-1), modw(WORDS-1) + 32'd1, "R8 last word");
    // R6 over-length -> full WORDS
    wr(ra(17), 32'd1000);
    cmd(32'd1);
    idle(WORDS);
    rd(ra(9), 0, "R6 over before");
    rd(ra(9), 1, "R6 over due");
    idle(2);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule